// File: doc/BRIEF.md
# Infrared Transceiver Bandwidth-Mode Sequencer

This block sits on the host side of an infrared transceiver. It drives the transceiver's shutdown/mode pin and its transmit data pin. Two settings exist: the slow group (SIR/MIR) and the fast setting (FIR). The transceiver takes its receiver bandwidth from the transmit pin level at the moment the shutdown pin falls. A request is a one-cycle start strobe with a target-mode bit. The block then plays a timed pattern on both pins. It reports busy while the pattern runs and pulses done for one cycle when the pattern ends.

When no sequence runs, the block keeps the shutdown pin low and passes the transmit bit from the serial encoder straight to the transmit pin. During a sequence it owns both pins and ignores the encoder's bit. Every interval is a minimum time given in picoseconds. Each is turned into a cycle count by `c(t) = floor(t / CLK_PERIOD_PS) + 1`, which is always at least the rounded-up value and is strictly longer than `t`.

The block stores the mode it last programmed. After reset this stored mode is the slow group, which is also the transceiver's default at power-on.

Top module: `irx_mode_seq`

## Requirements
- R1: While busy_o is low, sd_o is low and txd_o equals tx_data_i in the same cycle.
- R2: A start_i seen while idle makes busy_o high from the next cycle. In that first busy cycle sd_o is high and txd_o is low. tx_data_i has no effect on txd_o while busy_o is high.
- R3: Slow mode (fir_i = 0): txd_o stays low for the whole sequence. sd_o stays high for max(c(T_EDGE_PS), c(T_PULSE_PS)) cycles.
- R4: Fast mode (fir_i = 1): after sd_o rises, txd_o stays low for c(T_EDGE_PS) cycles. txd_o then goes high and stays high for max(c(T_EDGE_PS), c(T_PULSE_PS) - c(T_EDGE_PS)) cycles. sd_o falls at the end of that interval.
- R5: txd_o has the same value in the last cycle with sd_o high and in the first cycle with sd_o low. That value is 1 for fast mode and 0 for slow mode. After sd_o falls, sd_o stays low and txd_o keeps this level for c(T_HOLD_PS) busy cycles.
- R6: done_o is high for exactly one cycle: the first cycle after the hold interval, which is also the first cycle with busy_o low.
- R7: A start_i seen while busy_o is high is ignored. The running sequence keeps its mode and its lengths, and no second sequence follows.
- R8: After reset, mode_o is 0 (slow). It takes the requested mode bit (1 = fast) in the cycle sd_o falls and changes at no other time.
- R9: sd_o never stays high for c(T_QUAL_PS) consecutive cycles, so the transceiver is never put into full shutdown by a mode change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for a mode-programming sequence |
| fir_i | input | 1 | Target mode, sampled with start_i: 1 = fast, 0 = slow |
| tx_data_i | input | 1 | Transmit bit from the serial encoder |
| sd_o | output | 1 | Shutdown/mode pin to the transceiver |
| txd_o | output | 1 | Transmit pin to the transceiver |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when a sequence has finished |
| mode_o | output | 1 | Last programmed mode: 1 = fast, 0 = slow |

## Verification
The bench runs every ordered pair of target modes back to back: slow after slow, fast after slow, fast after fast, and slow after fast. This shows whether the stored mode follows each request or sticks at an earlier one.

During every sequence the encoder bit toggles each cycle. Any leak of tx_data_i into the programming pattern therefore shows up as a wrong low or high count.

Half of the runs also fire a second start with the opposite mode while busy. This separates a design that ignores the strobe from one that restarts or switches mode.

For each run the bench measures the shutdown-high length, the low lead-in before the transmit rise, the levels on both sides of the shutdown fall, the hold length and the done position. It compares them with counts it computes itself from the time parameters and the clock period.

// File: rtl/irx_mode_seq.sv
module irx_mode_seq #(
  parameter int CLK_PERIOD_PS = 20000,
  parameter int T_EDGE_PS     = 25000,
  parameter int T_PULSE_PS    = 50000,
  parameter int T_HOLD_PS     = 100000,
  parameter int T_QUAL_PS     = 400000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fir_i,
  input  logic tx_data_i,
  output logic sd_o,
  output logic txd_o,
  output logic busy_o,
  output logic done_o,
  output logic mode_o
);
  localparam int C_EDGE   = T_EDGE_PS / CLK_PERIOD_PS + 1;
  localparam int C_PULSE  = T_PULSE_PS / CLK_PERIOD_PS + 1;
  localparam int C_HOLD   = T_HOLD_PS / CLK_PERIOD_PS + 1;
  localparam int C_QUAL   = T_QUAL_PS / CLK_PERIOD_PS + 1;
  localparam int C_SIR_HI = (C_EDGE > C_PULSE) ? C_EDGE : C_PULSE;
  localparam int C_FIR_TX = (C_EDGE > C_PULSE - C_EDGE) ? C_EDGE : C_PULSE - C_EDGE;
  localparam int C_MAX_A  = (C_SIR_HI > C_FIR_TX) ? C_SIR_HI : C_FIR_TX;
  localparam int C_MAX    = (C_MAX_A > C_HOLD) ? C_MAX_A : C_HOLD;
  localparam int CW       = $clog2(C_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_SDHI, S_TXHI, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          fir_q, mode_q, done_q;
  logic          last;

  assign last   = (cnt == '0);
  assign busy_o = (st != S_IDLE);
  assign sd_o   = (st == S_SDHI) || (st == S_TXHI);
  assign txd_o  = (st == S_IDLE) ? tx_data_i
                                 : ((st == S_TXHI) || ((st == S_HOLD) && fir_q));
  assign done_o = done_q;
  assign mode_o = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      fir_q  <= 1'b0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          st    <= S_SDHI;
          fir_q <= fir_i;
          cnt   <= fir_i ? CW'(C_EDGE - 1) : CW'(C_SIR_HI - 1);
        end
        S_SDHI: if (!last) cnt <= cnt - 1'b1;
          else if (fir_q) begin
            st  <= S_TXHI;
            cnt <= CW'(C_FIR_TX - 1);
          end else begin
            st     <= S_HOLD;
            cnt    <= CW'(C_HOLD - 1);
            mode_q <= 1'b0;
          end
        S_TXHI: if (!last) cnt <= cnt - 1'b1;
          else begin
            st     <= S_HOLD;
            cnt    <= CW'(C_HOLD - 1);
            mode_q <= 1'b1;
          end
        default: if (!last) cnt <= cnt - 1'b1;
          else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
      endcase
    end
  end
endmodule

module irx_mode_seq_chk #(
  parameter int C_QUAL = 20001
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic tx_data_i,
  input logic sd_o,
  input logic txd_o,
  input logic busy_o,
  input logic done_o,
  input logic mode_o,
  input logic fir_q
);
  int sd_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sd_run <= 0;
    else sd_run <= sd_o ? sd_run + 1 : 0;

  p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sd_o && txd_o == tx_data_i));
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && sd_o && !txd_o));
  p_sir_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fir_q) |-> !txd_o);
  p_fall_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_o) |-> (txd_o == $past(txd_o) && txd_o == fir_q));
  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(fir_q));
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sd_o) |-> $stable(mode_o));
  p_sd_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sd_run < C_QUAL);
endmodule

bind irx_mode_seq irx_mode_seq_chk #(.C_QUAL(C_QUAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_data_i(tx_data_i),
  .sd_o(sd_o), .txd_o(txd_o), .busy_o(busy_o), .done_o(done_o),
  .mode_o(mode_o), .fir_q(fir_q)
);

// File: tb/irx_mode_seq_tb_top.sv
`timescale 1ns/1ps
module irx_mode_seq_tb_top;
  localparam int PER_PS  = 20000;
  localparam int EDGE_PS = 25000;
  localparam int PUL_PS  = 50000;
  localparam int HOLD_PS = 100000;
  localparam int QUAL_PS = 400000000;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, fir_i = 1'b0, tx_data_i = 1'b0;
  logic sd_o, txd_o, busy_o, done_o, mode_o;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irx_mode_seq #(.CLK_PERIOD_PS(PER_PS), .T_EDGE_PS(EDGE_PS), .T_PULSE_PS(PUL_PS),
                 .T_HOLD_PS(HOLD_PS), .T_QUAL_PS(QUAL_PS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fir_i(fir_i), .tx_data_i(tx_data_i),
    .sd_o(sd_o), .txd_o(txd_o), .busy_o(busy_o), .done_o(done_o), .mode_o(mode_o));

  function automatic int cyc(input int ps);
    return ps / PER_PS + 1;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic run(input bit f, input bit poke);
    int sd_cnt = 0, pre_cnt = 0, hold_cnt = 0, hold_bad = 0, n = 0;
    bit seen_tx = 0, last_hi_tx = 0, first_hold = 1, fall_ok = 1;
    int e_sd  = f ? cyc(EDGE_PS) + imax(cyc(EDGE_PS), cyc(PUL_PS) - cyc(EDGE_PS))
                  : imax(cyc(EDGE_PS), cyc(PUL_PS));
    int e_pre = f ? cyc(EDGE_PS) : e_sd;
    @(negedge clk); start_i = 1'b1; fir_i = f;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o && sd_o && !txd_o, "R2 first busy cycle", {busy_o, sd_o, txd_o}, 3'b110);
    while (busy_o && n < 200) begin
      if (sd_o) begin
        sd_cnt++;
        if (txd_o) seen_tx = 1;
        if (!txd_o && !seen_tx) pre_cnt++;
        last_hi_tx = txd_o;
      end else begin
        if (first_hold && txd_o != last_hi_tx) fall_ok = 0;
        first_hold = 0;
        hold_cnt++;
        if (txd_o != f) hold_bad++;
      end
      tx_data_i = ~tx_data_i;
      if (poke && n == 2) begin start_i = 1'b1; fir_i = ~f; end
      else start_i = 1'b0;
      n++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(n < 200, "watchdog sequence", n, 200);
    chk(sd_cnt == e_sd, f ? "R4 sd high length" : "R3 sd high length", sd_cnt, e_sd);
    chk(pre_cnt == e_pre, f ? "R4 txd low lead-in" : "R3 txd low throughout", pre_cnt, e_pre);
    chk(sd_cnt < cyc(QUAL_PS), "R9 sd below qualification", sd_cnt, cyc(QUAL_PS));
    chk(fall_ok && last_hi_tx == f, "R5 level around sd fall", last_hi_tx, f);
    chk(hold_cnt == cyc(HOLD_PS), "R5 hold length", hold_cnt, cyc(HOLD_PS));
    chk(hold_bad == 0, "R5 hold level", hold_bad, 0);
    chk(done_o && !busy_o, "R6 done at end", {done_o, busy_o}, 2'b10);
    chk(mode_o == f, "R8 mode updated", mode_o, f);
    tx_data_i = 1'b1; #1;
    chk(txd_o == 1'b1 && !sd_o, "R1 pass-through after sequence", txd_o, 1);
    @(negedge clk);
    chk(!done_o, "R6 done single cycle", done_o, 0);
    chk(!busy_o, poke ? "R7 start while busy ignored" : "R7 no extra sequence", busy_o, 0);
    tx_data_i = 1'b0;
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !sd_o, "R1 reset outputs", {busy_o, done_o, sd_o}, 0);
    chk(mode_o == 1'b0, "R8 reset mode", mode_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      tx_data_i = v[0]; #1;
      chk(txd_o == v[0] && !sd_o, "R1 idle pass-through", txd_o, v);
      @(negedge clk);
    end
    for (int rep = 0; rep < 2; rep++)
      for (int f = 0; f < 2; f++)
        for (int p = 0; p < 2; p++)
          run(f[0], p[0]);
    run(1'b0, 1'b1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule